// File: doc/BRIEF.md
# Multi-Polynomial CRC and Checksum Accelerator

This block takes the per-word work of computing a running CRC or a 16-bit ones'-complement sum off the processor. Software or a DMA engine drives a single-cycle register bus. It chooses an algorithm, bit order and feed width in a control register, and sets a starting value in the context register. It then writes the data one word or one byte at a time. Each write folds the new data into the context in a single clock. A one-cycle `done` pulse marks each data write.

The context holds the raw running value, and software can read it back or overwrite it at any time. A second read-only view gives the finished result. For a CRC, the finished result is the context bit-reversed and then complemented. For the checksum, it is the complement of the folded sum. Either view can be read between writes. The feed width and the CRC kind can be changed between writes without losing the context.

Top module: `crc_accel`

## Requirements
- R1: After reset, the control register reads 0, the context reads 0 and `done` is low. This selects the 16-bit 0x1021 CRC with word feed, MSb order and INIT 0.
- R2: The register map is: control at 0x400, context at 0x410, data input at 0x40C (write-only, reads 0) and result at 0x418. Reads return data combinationally while `bus_sel` is high and `bus_wr` is low. Every other offset reads 0.
- R3: The control register has these fields: kind in bits [2:0], byte feed in bit 4, LSb-first order in bit 5 and INIT in bits [9:8]. It reads back in the same positions. Kind 0 selects 16-bit polynomial 0x1021, kind 1 selects 16-bit 0x8005, kind 2 selects 32-bit 0x04C11DB7, kind 3 selects 32-bit 0x1EDC6F41, and kinds 4 to 7 select the checksum.
- R4: With MSb order, each data bit is shifted into a non-reflected CRC register starting from the highest bit. Kind 0 with the context set to ones and the ASCII digits 1 to 9 leaves the context at 0x000029B1.
- R5: With LSb order, bits enter lowest first, so the result register gives the standard reflected CRC. For the digits 1 to 9 it reads 0xCBF43926 for kind 2 and 0xE3069283 for kind 3, both starting from all ones. Kind 1 starting from zero reads 0x000044C2.
- R6: In word feed, all 32 bits of the data are used: with MSb order byte 3 goes first, and with LSb order byte 0 goes first. In byte feed, only bits [7:0] are used. The feed width may change between writes without disturbing the context.
- R7: Writing the control register with INIT 2 clears the context, and with INIT 3 sets it to all ones. INIT 0 and the reserved value 1 leave the context unchanged.
- R8: A write to the context register replaces the context with the written value, whatever the control settings are.
- R9: The result register returns the complement of the bit-reversed context. For the 16-bit kinds this uses only the low 16 bits, and the upper half of the result reads 0. After a data write in a 16-bit kind, context bits [31:16] read 0.
- R10: In checksum mode, a word write adds its two 16-bit halves to the sum and a byte write adds bits [7:0]. The sum folds in an end-around carry. The context holds the sum zero-extended, and the result reads its 16-bit complement.
- R11: `done` is high for exactly the one cycle after each data-input write. The context changes only on bus writes to the control, context or data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| done | output | 1 | Pulse after each data write |

## Verification
The hardest case to reach from the ports is a single message whose feed width changes in the middle. This is the only place where the byte ordering inside a word and the carry-over of context across a control write both matter at once. The bench feeds the first eight digits as two words and then rewrites the control register with INIT 0 and byte feed for the ninth digit. It checks the result against the published check value for the whole message, once in each bit order. Byte feed with junk in the upper bits is compared against a clean byte run.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

    localparam int unsigned DW      = 32;
    localparam int unsigned AW      = 12;
    localparam int unsigned SW      = 16;
    localparam int unsigned NUM_CRC = 4;
    localparam int unsigned IW      = $clog2(DW);

    localparam logic [AW-1:0] OFS_CTRL   = 12'h400;
    localparam logic [AW-1:0] OFS_DATA   = 12'h40C;
    localparam logic [AW-1:0] OFS_SEED   = 12'h410;
    localparam logic [AW-1:0] OFS_RESULT = 12'h418;

    localparam logic [1:0] INIT_ZERO = 2'd2;
    localparam logic [1:0] INIT_ONES = 2'd3;

    typedef struct packed {
        logic [1:0] init;
        logic       lsb_first;
        logic       byte_feed;
        logic [2:0] kind;
    } ctrl_t;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] ctx;
        logic          done;
    } state_t;

    function automatic logic [DW-1:0] ctrl_view(input ctrl_t c);
        return {22'b0, c.init, 2'b0, c.lsb_first, c.byte_feed, 1'b0, c.kind};
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [DW-1:0] w);
        ctrl_t c;
        c.init      = w[9:8];
        c.lsb_first = w[5];
        c.byte_feed = w[4];
        c.kind      = w[2:0];
        return c;
    endfunction

    function automatic logic [31:0] crc_poly(input int idx);
        case (idx)
            0:       return 32'h0000_1021;
            1:       return 32'h0000_8005;
            2:       return 32'h04C1_1DB7;
            default: return 32'h1EDC_6F41;
        endcase
    endfunction

    function automatic int crc_width(input int idx);
        return (idx < 2) ? 16 : 32;
    endfunction

endpackage

// File: rtl/crc_step_unit.sv
module crc_step_unit
    import crc_accel_pkg::*;
#(
    parameter int unsigned CW   = 16,
    parameter logic [31:0] POLY = 32'h0000_1021
) (
    input  logic [CW-1:0] ctx_i,
    input  logic [DW-1:0] data_i,
    input  logic          byte_feed_i,
    input  logic          lsb_first_i,
    output logic [DW-1:0] ctx_o
);

    logic [CW-1:0] c;
    logic          fb;
    logic [IW-1:0] idx;
    int            nb;

    always_comb begin
        c   = ctx_i;
        fb  = 1'b0;
        idx = '0;
        nb  = byte_feed_i ? 8 : int'(DW);
        for (int i = 0; i < int'(DW); i++) begin
            if (i < nb) begin
                idx = lsb_first_i ? IW'(i) : IW'(nb - 1 - i);
                fb  = c[CW-1] ^ data_i[idx];
                c   = {c[CW-2:0], 1'b0};
                if (fb) begin
                    c = c ^ POLY[CW-1:0];
                end
            end
        end
        ctx_o         = '0;
        ctx_o[CW-1:0] = c;
    end

endmodule

// File: rtl/csum_fold_unit.sv
module csum_fold_unit
    import crc_accel_pkg::*;
(
    input  logic [SW-1:0] sum_i,
    input  logic [DW-1:0] data_i,
    input  logic          byte_feed_i,
    output logic [DW-1:0] sum_o
);

    logic [SW+1:0] add_a;
    logic [SW+1:0] add_b;
    logic [SW+1:0] acc;
    logic [SW+1:0] fold1;
    logic [SW:0]   fold2;

    always_comb begin
        if (byte_feed_i) begin
            add_a = '0;
            add_b = {10'b0, data_i[7:0]};
        end else begin
            add_a = {2'b0, data_i[DW-1:SW]};
            add_b = {2'b0, data_i[SW-1:0]};
        end
        acc   = {2'b0, sum_i} + add_a + add_b;
        fold1 = {2'b0, acc[SW-1:0]} + {{SW{1'b0}}, acc[SW+1:SW]};
        fold2 = {1'b0, fold1[SW-1:0]} + {{SW{1'b0}}, fold1[SW]};
        sum_o = {{(DW-SW){1'b0}}, fold2[SW-1:0]};
    end

endmodule

// File: rtl/crc_post_unit.sv
module crc_post_unit
    import crc_accel_pkg::*;
(
    input  logic [DW-1:0] ctx_i,
    input  logic [2:0]    kind_i,
    output logic [DW-1:0] res_o
);

    logic [DW-1:0] rev_full;
    logic [SW-1:0] rev_half;

    always_comb begin
        for (int i = 0; i < int'(DW); i++) begin
            rev_full[i] = ctx_i[DW-1-i];
        end
        for (int i = 0; i < int'(SW); i++) begin
            rev_half[i] = ctx_i[SW-1-i];
        end
        if (kind_i[2]) begin
            res_o = {{(DW-SW){1'b0}}, ~ctx_i[SW-1:0]};
        end else if (kind_i[1]) begin
            res_o = ~rev_full;
        end else begin
            res_o = {{(DW-SW){1'b0}}, ~rev_half};
        end
    end

endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_accel_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          done
);

    state_t st_d;
    state_t st_q;

    logic [DW-1:0] ctx_q;
    logic [DW-1:0] crc_next [NUM_CRC];
    logic [DW-1:0] sum_next;
    logic [DW-1:0] upd;
    logic [DW-1:0] post_res;
    logic          wr_hit;
    ctrl_t         new_ctrl;

    assign ctx_q = st_q.ctx;
    assign done  = st_q.done;

    for (genvar g = 0; g < int'(NUM_CRC); g++) begin : g_poly
        localparam int unsigned CWG = crc_width(g);
        crc_step_unit #(
            .CW   (CWG),
            .POLY (crc_poly(g))
        ) u_step (
            .ctx_i       (ctx_q[CWG-1:0]),
            .data_i      (bus_wdata),
            .byte_feed_i (st_q.ctrl.byte_feed),
            .lsb_first_i (st_q.ctrl.lsb_first),
            .ctx_o       (crc_next[g])
        );
    end

    csum_fold_unit u_sum (
        .sum_i       (ctx_q[SW-1:0]),
        .data_i      (bus_wdata),
        .byte_feed_i (st_q.ctrl.byte_feed),
        .sum_o       (sum_next)
    );

    crc_post_unit u_post (
        .ctx_i  (ctx_q),
        .kind_i (st_q.ctrl.kind),
        .res_o  (post_res)
    );

    always_comb begin
        upd = st_q.ctrl.kind[2] ? sum_next : crc_next[st_q.ctrl.kind[1:0]];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wr_hit    = bus_sel && bus_wr;
        new_ctrl  = ctrl_decode(bus_wdata);
        if (wr_hit) begin
            case (bus_addr)
                OFS_CTRL: begin
                    st_d.ctrl = new_ctrl;
                    if (new_ctrl.init == INIT_ZERO) begin
                        st_d.ctx = '0;
                    end else if (new_ctrl.init == INIT_ONES) begin
                        st_d.ctx = '1;
                    end
                end
                OFS_SEED: st_d.ctx = bus_wdata;
                OFS_DATA: begin
                    st_d.ctx  = upd;
                    st_d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_CTRL:   bus_rdata = ctrl_view(st_q.ctrl);
                OFS_SEED:   bus_rdata = ctx_q;
                OFS_RESULT: bus_rdata = post_res;
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk
    import crc_accel_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          done,
    input logic [DW-1:0] ctx_q
);

    logic data_wr;
    logic ctrl_wr;
    logic seed_wr;
    logic mapped;

    assign data_wr = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign seed_wr = bus_sel && bus_wr && (bus_addr == OFS_SEED);
    assign mapped  = (bus_addr == OFS_CTRL) || (bus_addr == OFS_SEED) ||
                     (bus_addr == OFS_RESULT);

    // R11
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !done);

    // R7
    init_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[9:8] == INIT_ZERO) |=> (ctx_q == '0));

    // R7
    init_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[9:8] == INIT_ONES) |=> (ctx_q == '1));

    // R7
    init_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[9]) |=> $stable(ctx_q));

    // R8
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_wr |=> (ctx_q == $past(bus_wdata)));

    // R11
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(ctx_q));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == '0));

endmodule

bind crc_accel crc_accel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done      (done),
    .ctx_q     (ctx_q)
);

// File: tb/crc_accel_test.sv
module crc_accel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [11:0] A_CTRL = 12'h400;
    localparam logic [11:0] A_DATA = 12'h40C;
    localparam logic [11:0] A_SEED = 12'h410;
    localparam logic [11:0] A_RES  = 12'h418;

    crc_accel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input int kind, input bit byt,
                                       input bit lsb, input int init);
        return (32'(init) << 8) | (32'(lsb) << 5) | (32'(byt) << 4) | 32'(kind);
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic feed_digits(input bit byt_words);
        if (byt_words) begin
            for (int i = 0; i < 9; i++) bus_write(A_DATA, 32'h31 + 32'(i));
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 done after reset", {31'b0, done}, 32'h0);
        bus_read(A_CTRL, v); check("R1 ctrl after reset", v, 32'h0);
        bus_read(A_SEED, v); check("R1 context after reset", v, 32'h0);
        bus_read(A_RES, v);  check("R9 result of zero context", v, 32'h0000FFFF);
    endtask

    task automatic t_map();
        logic [31:0] v;
        bus_write(A_CTRL, mk(3, 1, 1, 1));
        bus_read(A_CTRL, v); check("R3 ctrl readback", v, 32'h0000_0133);
        bus_read(12'h404, v); check("R2 unmapped 0x404", v, 32'h0);
        bus_read(12'h000, v); check("R2 unmapped 0x000", v, 32'h0);
        bus_read(A_DATA, v);  check("R2 data offset reads zero", v, 32'h0);
    endtask

    task automatic t_init();
        logic [31:0] v;
        bus_write(A_SEED, 32'hDEADBEEF);
        bus_read(A_SEED, v); check("R8 seed write", v, 32'hDEADBEEF);
        bus_write(A_CTRL, mk(2, 0, 0, 0));
        bus_read(A_SEED, v); check("R7 init 0 keeps", v, 32'hDEADBEEF);
        bus_write(A_CTRL, mk(2, 0, 0, 1));
        bus_read(A_SEED, v); check("R7 init 1 keeps", v, 32'hDEADBEEF);
        bus_write(A_CTRL, mk(2, 0, 0, 2));
        bus_read(A_SEED, v); check("R7 init 2 clears", v, 32'h0);
        bus_write(A_CTRL, mk(2, 0, 0, 3));
        bus_read(A_SEED, v); check("R7 init 3 sets ones", v, 32'hFFFFFFFF);
        bus_write(A_CTRL, mk(4, 1, 1, 3));
        bus_write(A_SEED, 32'h12345678);
        bus_read(A_SEED, v); check("R8 seed write in sum mode", v, 32'h12345678);
    endtask

    task automatic t_msb_mixed();
        logic [31:0] v;
        bus_write(A_CTRL, mk(0, 0, 0, 3));
        bus_write(A_DATA, 32'h31323334);
        bus_write(A_DATA, 32'h35363738);
        bus_write(A_CTRL, mk(0, 1, 0, 0));
        bus_write(A_DATA, 32'h00000039);
        bus_read(A_SEED, v); check("R4 R6 kind0 msb mixed feed", v, 32'h000029B1);
        bus_read(A_RES, v);  check("R9 kind0 post result", v, 32'h0000726B);
    endtask

    task automatic t_lsb();
        logic [31:0] v;
        bus_write(A_CTRL, mk(2, 0, 1, 3));
        bus_write(A_DATA, 32'h34333231);
        bus_write(A_DATA, 32'h38373635);
        bus_write(A_CTRL, mk(2, 1, 1, 0));
        bus_write(A_DATA, 32'h00000039);
        bus_read(A_RES, v); check("R5 R6 kind2 lsb mixed feed", v, 32'hCBF43926);
        bus_write(A_CTRL, mk(3, 1, 1, 3));
        feed_digits(1'b1);
        bus_read(A_RES, v); check("R5 kind3 lsb bytes", v, 32'hE3069283);
        bus_write(A_CTRL, mk(1, 1, 1, 2));
        feed_digits(1'b1);
        bus_read(A_RES, v); check("R5 kind1 lsb bytes", v, 32'h000044C2);
        bus_read(A_SEED, v); check("R9 16-bit upper context zero", v & 32'hFFFF0000, 32'h0);
    endtask

    task automatic t_feed();
        logic [31:0] a, b;
        bus_write(A_CTRL, mk(2, 0, 0, 3));
        bus_write(A_DATA, 32'hA1B2C3D4);
        bus_read(A_SEED, a);
        bus_write(A_CTRL, mk(2, 1, 0, 3));
        bus_write(A_DATA, 32'h000000A1);
        bus_write(A_DATA, 32'h000000B2);
        bus_write(A_DATA, 32'h000000C3);
        bus_write(A_DATA, 32'h000000D4);
        bus_read(A_SEED, b);
        check("R6 msb word equals bytes 3..0", a, b);
        bus_write(A_CTRL, mk(3, 1, 0, 3));
        bus_write(A_DATA, 32'h00000039);
        bus_read(A_SEED, a);
        bus_write(A_CTRL, mk(3, 1, 0, 3));
        bus_write(A_DATA, 32'hABCDEF39);
        bus_read(A_SEED, b);
        check("R6 byte feed ignores upper bits", b, a);
    endtask

    task automatic t_sum();
        logic [31:0] v;
        bus_write(A_CTRL, mk(4, 0, 0, 2));
        bus_write(A_DATA, 32'h12345678);
        bus_read(A_SEED, v); check("R10 sum of halves", v, 32'h000068AC);
        bus_write(A_DATA, 32'hFFFF0001);
        bus_read(A_SEED, v); check("R10 end-around carry", v, 32'h000068AD);
        bus_write(A_CTRL, mk(7, 1, 0, 0));
        bus_write(A_DATA, 32'hFFFFFF55);
        bus_read(A_SEED, v); check("R10 byte add", v, 32'h00006902);
        bus_read(A_RES, v);  check("R10 complemented result", v, 32'h000096FD);
    endtask

    task automatic t_done();
        logic [31:0] a, b;
        bus_write(A_CTRL, mk(2, 0, 0, 3));
        check("R11 no done after ctrl write", {31'b0, done}, 32'h0);
        bus_write(A_DATA, 32'h01020304);
        check("R11 done after data write", {31'b0, done}, 32'h1);
        @(negedge clk);
        check("R11 done drops", {31'b0, done}, 32'h0);
        bus_read(A_SEED, a);
        bus_write(12'h500, 32'h55555555);
        bus_read(A_RES, b);
        bus_read(A_SEED, b);
        check("R11 context holds on other access", b, a);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_init();
        t_msb_mixed();
        t_lsb();
        t_feed();
        t_sum();
        t_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule